// File: doc/BRIEF.md
# Circular Fault Record Queue

This block takes fault events from an address-translation pipeline and turns each one into a 32-byte record in a circular buffer held in system memory. Events arrive on a valid/ready stream. A small input FIFO holds them, and a writer drains the FIFO into memory as four 64-bit beats on a valid/ready write port. Software owns the head index and reads records up to the tail index, which the hardware advances. When a record completes, the block sets a pending flag. It raises an interrupt request if interrupts are enabled.

The buffer always leaves one slot empty, so a buffer of N slots holds at most N-1 records. An event that arrives when the buffer is full is discarded and sets a sticky overflow flag. Events are drained only while the queue is enabled. Clearing the enable bit flushes every event still waiting in the input FIFO.

Back-pressure works as follows. `evt_ready` is low while the input FIFO is full. An event is taken on a clock edge where `evt_valid` and `evt_ready` are both high. A memory beat completes on a clock edge where `mem_valid` and `mem_ready` are both high. `mem_valid` stays high, with its address and data held, until that edge. Software must not rewrite the base register while a record is being written.

Register map, selected by a 2-bit index:
- 0: base. Bits 4:0 hold log2(slots)-1, clamped to MAX_LOG2. The upper bits hold the buffer address shifted right by 2, so the buffer sits on a 4 KiB boundary.
- 1: head.
- 2: tail (read-only).
- 3: control/status.

Top module: `fault_rec_queue`

## Requirements
- R1: After reset, head, tail and control/status all read 0, `irq` and `mem_valid` are low, and `evt_ready` is high.
- R2: A record is four beats. Beat k is written to `base_addr + tail*32 + k*8`, where `base_addr` is base[31:10] shifted left by 12.
  - Beat 0 carries the device ID in bits 63:40, the transaction type in 39:34 and the cause in 11:0, with all other bits zero.
  - Beat 1 is zero.
  - Beat 2 is the faulting address.
  - Beat 3 is the guest address with bits 1:0 cleared, then bit 0 set to the implicit flag and bit 1 set to (implicit AND write).
- R3: The slot count is 2^min(base[4:0]+1, MAX_LOG2). For example, a field value of 1 gives 4 slots.
- R4: Once the fourth beat of a record is accepted, the tail becomes (tail+1) mod slots.
- R5: When (tail+1) mod slots equals head, the next drained event causes no memory write and sets overflow, which is control/status bit 9.
- R6: Control/status bits 8 (pending) and 9 (overflow) clear when they are written with 1. Writing 0 to them leaves them unchanged. Bit 0 (enable) and bit 1 (interrupt enable) take the written value.
- R7: The pending bit sets each time a record completes. `irq` is high exactly when pending and interrupt enable are both set.
- R8: Events are drained only while enable is set. While enable is clear, the FIFO is emptied and incoming events are accepted and discarded. A record already in progress still completes.
- R9: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_data` hold their values into the next cycle.
- R10: `evt_ready` is low exactly while the input FIFO holds FIFO_DEPTH events.
- R11: Control/status bit 16 (busy) is high while a record is being written.
- R12: A write to head stores the value masked to the slot count. Writes to tail are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 2 | Register write index |
| reg_wdata | input | REG_W | Register write data |
| reg_raddr | input | 2 | Register read index |
| reg_rdata | output | REG_W | Register read data (combinational) |
| evt_valid | input | 1 | Fault event valid |
| evt_ready | output | 1 | Fault event accepted when high with valid |
| evt_cause | input | 12 | Fault cause code |
| evt_ttype | input | 6 | Transaction type |
| evt_dev | input | 24 | Device ID |
| evt_addr | input | 64 | Faulting address |
| evt_gpa | input | 64 | Guest address value |
| evt_implicit | input | 1 | Fault came from an implicit access |
| evt_write | input | 1 | Implicit access was a write |
| mem_valid | output | 1 | Memory write beat valid |
| mem_ready | input | 1 | Memory accepts the beat |
| mem_addr | output | REG_W+2 | Beat byte address |
| mem_data | output | 64 | Beat data |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check four cycle-level properties on every cycle:
- a stalled memory beat holds still;
- the tail moves only on an accepted beat;
- pending rises only right after an accepted beat;
- overflow and new memory traffic start only while the queue is enabled.

Some behaviour can only be shown by the bench scenarios, which compare against a behavioural model on every clock. These are the record layout, the full and overflow decision against a software-moved head, tail wrap-around, slot-count clamping, and the flush that happens on disable.

// File: rtl/fltq_pkg.sv
package fltq_pkg;
  localparam int CAUSE_W = 12;
  localparam int TTYPE_W = 6;
  localparam int DEV_W = 24;
  localparam int WORD_W = 64;
  localparam int REC_BEATS = 4;
  localparam int BEAT_W = $clog2(REC_BEATS);
  localparam int REC_SHIFT = 5; // 32-byte records
  localparam int BEAT_SHIFT = 3; // 8-byte beats

  typedef struct packed {
    logic [CAUSE_W-1:0] cause;
    logic [TTYPE_W-1:0] ttype;
    logic [DEV_W-1:0] dev;
    logic [WORD_W-1:0] addr;
    logic [WORD_W-1:0] gpa;
    logic implicit_acc;
    logic wr;
  } fltq_evt_t;

  function automatic logic [WORD_W-1:0] rec_word(fltq_evt_t e, logic [BEAT_W-1:0] idx);
    logic [WORD_W-1:0] w;
    w = '0;
    case (idx)
      2'd0: begin
        w[63:40] = e.dev;
        w[39:34] = e.ttype;
        w[11:0] = e.cause;
      end
      2'd1: w = '0;
      2'd2: w = e.addr;
      default: w = {e.gpa[WORD_W-1:2], e.implicit_acc & e.wr, e.implicit_acc};
    endcase
    return w;
  endfunction
endpackage

// File: rtl/fltq_fifo.sv
module fltq_fifo #(
  parameter int DEPTH = 4,
  parameter int W = 8
) (
  input logic clk,
  input logic rst_n,
  input logic flush,
  input logic push,
  input logic [W-1:0] din,
  input logic pop,
  output logic [W-1:0] dout,
  output logic empty,
  output logic full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0] mem_q [DEPTH];
  logic [AW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [AW-1:0] nxt(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (cnt_q == '0);
  assign full = (cnt_q == CW'(DEPTH));
  assign dout = mem_q[rd_q];

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      rd_q <= '0;
      wr_q <= '0;
      cnt_q <= '0;
    end else begin
      if (push) begin
        mem_q[wr_q] <= din;
        wr_q <= nxt(wr_q);
      end
      if (pop) rd_q <= nxt(rd_q);
      if (push && !pop) cnt_q <= cnt_q + 1'b1;
      else if (pop && !push) cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/fltq_regs.sv
module fltq_regs #(
  parameter int REG_W = 32,
  parameter int MAX_LOG2 = 4,
  parameter int PTR_W = 4
) (
  input logic clk,
  input logic rst_n,
  input logic reg_we,
  input logic [1:0] reg_waddr,
  input logic [REG_W-1:0] reg_wdata,
  input logic [1:0] reg_raddr,
  output logic [REG_W-1:0] reg_rdata,
  input logic [PTR_W-1:0] tail,
  input logic busy,
  input logic ovf_set,
  input logic pend_set,
  output logic en,
  output logic ie,
  output logic pend,
  output logic ovf,
  output logic [PTR_W-1:0] head,
  output logic [PTR_W-1:0] mask,
  output logic [REG_W+1:0] base_addr
);
  localparam int LOGF_W = 5;
  localparam int ALIGN = 12;
  localparam int ADDR_LSB = ALIGN - 2;

  logic [REG_W-1:0] base_q;
  logic [PTR_W-1:0] head_q;
  logic en_q, ie_q, pend_q, ovf_q;
  int unsigned sz;

  always_comb begin
    sz = int'(base_q[LOGF_W-1:0]) + 1;
    if (sz > MAX_LOG2) sz = MAX_LOG2;
    mask = PTR_W'((1 << sz) - 1);
  end

  assign base_addr = {base_q[REG_W-1:ADDR_LSB], {ALIGN{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      head_q <= '0;
      en_q <= 1'b0;
      ie_q <= 1'b0;
      pend_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      if (reg_we) begin
        case (reg_waddr)
          2'd0: base_q <= reg_wdata;
          2'd1: head_q <= reg_wdata[PTR_W-1:0] & mask;
          2'd3: begin
            en_q <= reg_wdata[0];
            ie_q <= reg_wdata[1];
          end
          default: ;
        endcase
      end
      pend_q <= (pend_q & ~(reg_we && reg_waddr == 2'd3 && reg_wdata[8])) | pend_set;
      ovf_q <= (ovf_q & ~(reg_we && reg_waddr == 2'd3 && reg_wdata[9])) | ovf_set;
    end
  end

  always_comb begin
    case (reg_raddr)
      2'd0: reg_rdata = base_q;
      2'd1: reg_rdata = REG_W'(head_q);
      2'd2: reg_rdata = REG_W'(tail);
      default: reg_rdata = REG_W'({busy, 6'b0, ovf_q, pend_q, 6'b0, ie_q, en_q});
    endcase
  end

  assign en = en_q;
  assign ie = ie_q;
  assign pend = pend_q;
  assign ovf = ovf_q;
  assign head = head_q;
endmodule

// File: rtl/fltq_writer.sv
module fltq_writer
  import fltq_pkg::*;
#(
  parameter int PTR_W = 4,
  parameter int MA_W = 34
) (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic [PTR_W-1:0] head,
  input logic [PTR_W-1:0] mask,
  input logic [MA_W-1:0] base_addr,
  input logic fifo_empty,
  input fltq_evt_t fifo_dout,
  output logic pop,
  output logic mem_valid,
  input logic mem_ready,
  output logic [MA_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_data,
  output logic [PTR_W-1:0] tail,
  output logic busy,
  output logic ovf_set,
  output logic pend_set
);
  typedef enum logic {WR_IDLE, WR_BEAT} wr_st_e;

  wr_st_e st_q;
  logic [BEAT_W-1:0] beat_q;
  logic [PTR_W-1:0] tail_q;
  fltq_evt_t rec_q;
  logic full, fire, last;
  logic [PTR_W-1:0] tail_inc;

  assign tail_inc = (tail_q + 1'b1) & mask;
  assign full = (tail_inc == (head & mask));
  assign pop = (st_q == WR_IDLE) && en && !fifo_empty;
  assign ovf_set = pop && full;
  assign mem_valid = (st_q == WR_BEAT);
  assign fire = mem_valid && mem_ready;
  assign last = (beat_q == BEAT_W'(REC_BEATS - 1));
  assign pend_set = fire && last;
  assign busy = mem_valid;
  assign tail = tail_q;

  assign mem_addr = base_addr
                  + MA_W'({tail_q & mask, {REC_SHIFT{1'b0}}})
                  + MA_W'({beat_q, {BEAT_SHIFT{1'b0}}});
  assign mem_data = rec_word(rec_q, beat_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= WR_IDLE;
      beat_q <= '0;
      tail_q <= '0;
      rec_q <= '0;
    end else begin
      case (st_q)
        WR_IDLE: if (pop && !full) begin
          rec_q <= fifo_dout;
          beat_q <= '0;
          st_q <= WR_BEAT;
        end
        default: if (fire) begin
          if (last) begin
            tail_q <= tail_inc;
            st_q <= WR_IDLE;
          end else begin
            beat_q <= beat_q + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/fault_rec_queue.sv
module fault_rec_queue
  import fltq_pkg::*;
#(
  parameter int REG_W = 32,
  parameter int FIFO_DEPTH = 4,
  parameter int MAX_LOG2 = 4
) (
  input logic clk,
  input logic rst_n,
  input logic reg_we,
  input logic [1:0] reg_waddr,
  input logic [REG_W-1:0] reg_wdata,
  input logic [1:0] reg_raddr,
  output logic [REG_W-1:0] reg_rdata,
  input logic evt_valid,
  output logic evt_ready,
  input logic [11:0] evt_cause,
  input logic [5:0] evt_ttype,
  input logic [23:0] evt_dev,
  input logic [63:0] evt_addr,
  input logic [63:0] evt_gpa,
  input logic evt_implicit,
  input logic evt_write,
  output logic mem_valid,
  input logic mem_ready,
  output logic [REG_W+1:0] mem_addr,
  output logic [63:0] mem_data,
  output logic irq
);
  localparam int PTR_W = MAX_LOG2;
  localparam int MA_W = REG_W + 2;
  localparam int EVT_W = $bits(fltq_evt_t);

  logic en, ie, pend, ovf, busy, ovf_set, pend_set, pop;
  logic fifo_empty, fifo_full;
  logic [PTR_W-1:0] head, tail, mask;
  logic [MA_W-1:0] base_addr;
  fltq_evt_t evt_in, evt_out;
  logic [EVT_W-1:0] fifo_q;

  assign evt_in = '{cause: evt_cause, ttype: evt_ttype, dev: evt_dev, addr: evt_addr,
                    gpa: evt_gpa, implicit_acc: evt_implicit, wr: evt_write};
  assign evt_ready = !fifo_full;
  assign evt_out = fltq_evt_t'(fifo_q);
  assign irq = ie && pend;

  fltq_fifo #(.DEPTH(FIFO_DEPTH), .W(EVT_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(!en),
    .push(evt_valid && !fifo_full), .din(EVT_W'(evt_in)),
    .pop(pop), .dout(fifo_q), .empty(fifo_empty), .full(fifo_full)
  );

  fltq_regs #(.REG_W(REG_W), .MAX_LOG2(MAX_LOG2), .PTR_W(PTR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .tail(tail), .busy(busy), .ovf_set(ovf_set), .pend_set(pend_set),
    .en(en), .ie(ie), .pend(pend), .ovf(ovf), .head(head), .mask(mask),
    .base_addr(base_addr)
  );

  fltq_writer #(.PTR_W(PTR_W), .MA_W(MA_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .en(en), .head(head), .mask(mask),
    .base_addr(base_addr), .fifo_empty(fifo_empty), .fifo_dout(evt_out),
    .pop(pop), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_data(mem_data), .tail(tail), .busy(busy),
    .ovf_set(ovf_set), .pend_set(pend_set)
  );
endmodule

// File: rtl/fltq_chk.sv
module fltq_chk #(
  parameter int MA_W = 34,
  parameter int PTR_W = 4
) (
  input logic clk,
  input logic rst_n,
  input logic mem_valid,
  input logic mem_ready,
  input logic [MA_W-1:0] mem_addr,
  input logic [63:0] mem_data,
  input logic [PTR_W-1:0] tail,
  input logic en,
  input logic pend,
  input logic ovf
);
  // R9
  beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data));

  // R4
  tail_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tail) |-> $past(mem_valid && mem_ready));

  // R7
  pend_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(mem_valid && mem_ready));

  // R5
  ovf_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> $past(en));

  // R8
  start_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_valid) |-> $past(en));
endmodule

bind fault_rec_queue fltq_chk #(.MA_W(MA_W), .PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_addr(mem_addr), .mem_data(mem_data), .tail(tail), .en(en),
  .pend(pend), .ovf(ovf)
);

// File: tb/sim_fault_rec_queue.sv
module sim_fault_rec_queue;
  localparam int FD = 4;
  localparam int ML = 4;

  typedef struct {
    logic [11:0] cause;
    logic [5:0] ttype;
    logic [23:0] dev;
    logic [63:0] addr;
    logic [63:0] gpa;
    logic imp;
    logic wr;
  } ev_t;

  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic reg_we = 0;
  logic [1:0] reg_waddr = 0, reg_raddr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic evt_valid = 0, evt_ready, evt_implicit = 0, evt_write = 0;
  logic [11:0] evt_cause = 0;
  logic [5:0] evt_ttype = 0;
  logic [23:0] evt_dev = 0;
  logic [63:0] evt_addr = 0, evt_gpa = 0, mem_data;
  logic mem_valid, mem_ready = 0, irq;
  logic [33:0] mem_addr;

  fault_rec_queue #(.REG_W(32), .FIFO_DEPTH(FD), .MAX_LOG2(ML)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_cause(evt_cause),
    .evt_ttype(evt_ttype), .evt_dev(evt_dev), .evt_addr(evt_addr),
    .evt_gpa(evt_gpa), .evt_implicit(evt_implicit), .evt_write(evt_write),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_data(mem_data), .irq(irq)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0, rmode = 2;
  bit rd_hold = 0, done = 0, prev_stall = 0;
  logic [33:0] prev_addr;
  logic [63:0] prev_data;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Behavioural reference model
  ev_t mq[$];
  ev_t mrec;
  int m_st = 0, m_beat = 0;
  logic [3:0] m_tail = 0, m_head = 0;
  logic [31:0] m_base = 0;
  bit m_en = 0, m_ie = 0, m_pend = 0, m_ovf = 0;

  function automatic int m_mask();
    int l = int'(m_base[4:0]) + 1;
    if (l > ML) l = ML;
    return (1 << l) - 1;
  endfunction

  function automatic logic [63:0] exp_word(ev_t e, int b);
    case (b)
      0: return (64'(e.dev) << 40) | (64'(e.ttype) << 34) | 64'(e.cause);
      1: return 64'd0;
      2: return e.addr;
      default: return (e.gpa & ~64'd3) | 64'(e.imp) | (64'(e.imp & e.wr) << 1);
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete();
      m_st = 0; m_beat = 0; m_tail = 0; m_head = 0; m_base = 0;
      m_en = 0; m_ie = 0; m_pend = 0; m_ovf = 0;
    end else begin
      int mk, osz;
      bit pop, ovs, pds;
      ev_t cur;
      mk = m_mask();
      osz = mq.size();
      ovs = 0; pds = 0;
      pop = (m_st == 0) && m_en && osz > 0;
      if (m_st == 1) begin
        if (mem_ready) begin
          if (m_beat == 3) begin
            m_tail = 4'((int'(m_tail) + 1) & mk);
            pds = 1;
            m_st = 0;
          end else m_beat++;
        end
      end else if (pop) begin
        if (((int'(m_tail) + 1) & mk) == (int'(m_head) & mk)) ovs = 1;
        else begin
          mrec = mq[0];
          m_st = 1;
          m_beat = 0;
        end
      end
      if (!m_en) mq.delete();
      else begin
        if (pop) void'(mq.pop_front());
        if (evt_valid && osz < FD) begin
          cur.cause = evt_cause; cur.ttype = evt_ttype; cur.dev = evt_dev;
          cur.addr = evt_addr; cur.gpa = evt_gpa; cur.imp = evt_implicit; cur.wr = evt_write;
          mq.push_back(cur);
        end
      end
      if (reg_we) begin
        case (reg_waddr)
          2'd0: m_base = reg_wdata;
          2'd1: m_head = 4'(int'(reg_wdata[3:0]) & mk);
          2'd3: begin
            m_en = reg_wdata[0];
            m_ie = reg_wdata[1];
            if (reg_wdata[8]) m_pend = 0;
            if (reg_wdata[9]) m_ovf = 0;
          end
          default: ;
        endcase
      end
      if (pds) m_pend = 1;
      if (ovs) m_ovf = 1;
    end
  end

  // Input drivers that run every cycle
  always @(negedge clk) begin
    cyc++;
    mem_ready = (rmode == 0) ? 1'b0 : (rmode == 1) ? (cyc % 3 != 0) : 1'b1;
    if (!rd_hold) reg_raddr = 2'(cyc);
  end

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    #5;
    if (rst_n && !done) begin
      logic [63:0] ea, er;
      ea = (64'(m_base[31:10]) << 12) + 64'((int'(m_tail) & m_mask()) * 32) + 64'(m_beat * 8);
      chk("R10 evt_ready", 64'(evt_ready), 64'(mq.size() < FD));
      chk("R8 mem_valid", 64'(mem_valid), 64'(m_st == 1));
      chk("R7 irq", 64'(irq), 64'(m_ie && m_pend));
      if (m_st == 1) begin
        chk("R2 R3 R4 mem_addr", 64'(mem_addr), ea);
        chk("R2 mem_data", mem_data, exp_word(mrec, m_beat));
      end
      if (prev_stall) begin
        chk("R9 held mem_addr", 64'(mem_addr), 64'(prev_addr));
        chk("R9 held mem_data", mem_data, prev_data);
      end
      prev_stall = mem_valid && !mem_ready;
      prev_addr = mem_addr;
      prev_data = mem_data;
      case (reg_raddr)
        2'd0: er = 64'(m_base);
        2'd1: er = 64'(m_head);
        2'd2: er = 64'(m_tail);
        default: er = (64'(m_st == 1) << 16) | (64'(m_ovf) << 9) | (64'(m_pend) << 8)
                      | (64'(m_ie) << 1) | 64'(m_en);
      endcase
      chk("R6 R12 reg_rdata", 64'(reg_rdata), er);
    end
  end

  task automatic wreg(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_waddr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic peek(logic [1:0] a, output logic [31:0] v);
    rd_hold = 1;
    @(negedge clk);
    reg_raddr = a;
    #5;
    v = reg_rdata;
    rd_hold = 0;
  endtask

  task automatic send(logic [11:0] c, logic [5:0] t, logic [23:0] d,
                      logic [63:0] a, logic [63:0] g, logic im, logic w);
    @(negedge clk);
    evt_valid = 1; evt_cause = c; evt_ttype = t; evt_dev = d;
    evt_addr = a; evt_gpa = g; evt_implicit = im; evt_write = w;
    forever begin
      #5;
      if (evt_ready) begin
        @(posedge clk);
        break;
      end
      @(negedge clk);
    end
    @(negedge clk);
    evt_valid = 0;
  endtask

  initial begin
    #(20 * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v, t_save;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 mem_valid", 64'(mem_valid), 0);
    chk("R1 irq", 64'(irq), 0);
    chk("R1 evt_ready", 64'(evt_ready), 1);
    peek(2'd3, v); chk("R1 csr", 64'(v), 0);
    peek(2'd2, v); chk("R1 tail", 64'(v), 0);
    @(negedge clk); rst_n = 1;

    // Scenario: four slots, head 0, four faults -> three records, overflow
    rmode = 1;
    wreg(2'd0, (32'h1000B << 10) | 32'd1);
    wreg(2'd3, 32'h3);
    for (int i = 0; i < 4; i++)
      send(i > 1 ? 12'd13 : 12'd15, i > 1 ? 6'd2 : 6'd3, 24'd2,
           64'h1000000001c + 64'(4 * i), 64'h1000000001f + 64'(4 * i), 1'b1, i < 2);
    repeat (40) @(posedge clk);
    peek(2'd2, v); chk("R4 tail after three records", 64'(v), 3);
    peek(2'd3, v); chk("R5 overflow flag", 64'(v[9]), 1);
    chk("R7 irq raised", 64'(irq), 1);
    wreg(2'd3, 32'h303);
    peek(2'd3, v); chk("R6 w1c clears pending and overflow", 64'(v), 3);
    wreg(2'd2, 32'd0);
    peek(2'd2, v); chk("R12 tail write ignored", 64'(v), 3);

    // Scenario: head moved to 3, tail wraps 3->0->1
    wreg(2'd1, 32'd7);
    peek(2'd1, v); chk("R12 head masked", 64'(v), 3);
    send(12'd7, 6'd1, 24'hABCDEF, 64'h2000, 64'h3002, 1'b0, 1'b1);
    send(12'd8, 6'd2, 24'h000123, 64'h2008, 64'h300b, 1'b1, 1'b0);
    repeat (30) @(posedge clk);
    peek(2'd2, v); chk("R4 tail wrap", 64'(v), 1);

    // Scenario: memory stalled, busy and FIFO back-pressure
    rmode = 0;
    send(12'd5, 6'd4, 24'd9, 64'h40, 64'h44, 1'b0, 1'b0);
    repeat (3) @(posedge clk);
    peek(2'd3, v); chk("R11 busy while writing", 64'(v[16]), 1);
    for (int i = 0; i < FD; i++) send(12'd6, 6'd5, 24'd10 + 24'(i), 64'h80, 64'h88, 1'b1, 1'b1);
    #5; chk("R10 evt_ready low when FIFO full", 64'(evt_ready), 0);

    // Scenario: disable flushes FIFO while record finishes
    wreg(2'd3, 32'h2);
    rmode = 1;
    repeat (20) @(posedge clk);
    peek(2'd2, t_save);
    chk("R8 idle after disable", 64'(mem_valid), 0);
    send(12'd9, 6'd3, 24'd4, 64'h100, 64'h104, 1'b0, 1'b0);
    repeat (10) @(posedge clk);
    peek(2'd2, v); chk("R8 no drain while disabled", 64'(v), 64'(t_save));
    wreg(2'd3, 32'h300);
    peek(2'd3, v); chk("R6 status zero after disable", 64'(v), 0);

    // Scenario: two-slot buffer, then clamped sixteen-slot buffer
    wreg(2'd0, 32'h2000 << 10);
    wreg(2'd1, 32'd0);
    wreg(2'd3, 32'h1);
    for (int i = 0; i < 3; i++) send(12'd3, 6'd1, 24'd5, 64'h500 + 64'(i), 64'h600, 1'b0, 1'b0);
    repeat (30) @(posedge clk);
    peek(2'd3, v); chk("R3 two-slot overflow", 64'(v[9]), 1);
    wreg(2'd0, (32'h3000 << 10) | 32'd31);
    wreg(2'd3, 32'h301);
    for (int i = 0; i < 5; i++) send(12'd15, 6'd3, 24'd6, 64'h700 + 64'(8 * i), 64'h800, 1'b1, 1'b1);
    repeat (40) @(posedge clk);
    peek(2'd3, v); chk("R3 sixteen slots no overflow", 64'(v[9]), 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule